// File: doc/BRIEF.md
# Next-PC Target Predictor

This block sits beside the instruction memory in the fetch stage and proposes the address to fetch next. Each cycle it looks the fetch PC up in a direct-mapped, tagged target array. The lookup is combinational, so the answer is ready in the same cycle as the instruction word. A hit returns the full target address that was stored for that PC. A miss returns the sequential address PC+4.

A small circular return stack handles return instructions. A fetch that pre-decode marks as a call pushes its fall-through address PC+4. A fetch marked as a return uses the top of the stack as its target, in place of the target array, and pops it. A resolve port arrives later from the back end and carries the branch PC, the real target and the target that was predicted. The target array is written only when those two targets differ.

Top module: `nextpc_predictor`

## Requirements
- R1: The array index is `fetch_pc[9:2]` and the tag is `fetch_pc[31:10]`. Bits [1:0] take no part in the lookup, so two PCs that differ only in those bits find the same entry.
- R2: A hit needs a valid entry whose stored tag equals the PC upper bits. A PC with the same index but a different tag misses.
- R3: Reset clears every valid bit and empties the return stack. Straight after reset, no PC hits.
- R4: On a miss with no return-stack override, `pred_hit` is 0 and `pred_target` is `fetch_pc + 4`.
- R5: A resolve with `rslv_target != rslv_pred_target` writes the entry for `rslv_pc` with its tag and the full 32-bit target. From the next cycle on, a fetch of that PC hits with that target.
- R6: A resolve with `rslv_target == rslv_pred_target` leaves the array unchanged. A missing entry stays missing, and an existing entry keeps its old target.
- R7: The prediction for a fetch PC is valid in the same cycle that the PC is presented.
- R8: A valid fetch marked as a call pushes `fetch_pc + 4`. A valid fetch marked as a return, with a non-empty stack, gives `pred_hit` = 1 with the top of the stack as the target, and pops it.
- R9: Returns take the pushed addresses back in last-in, first-out order.
- R10: The stack holds RAS_DEPTH (default 8) entries. A push onto a full stack overwrites the oldest entry. After RAS_DEPTH+1 calls, RAS_DEPTH returns give the newest RAS_DEPTH addresses, and the stack is then empty.
- R11: A return on an empty stack falls back to the target-array result, and the stack stays empty.
- R12: For a return with a non-empty stack, the stack value overrides a target-array hit.
- R13: When `fetch_valid` is 0, the call and return flags neither push nor pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_valid | input | 1 | A fetch is issued this cycle |
| fetch_pc | input | 32 | Fetch address |
| fetch_is_call | input | 1 | Pre-decode mark: the fetched instruction is a call |
| fetch_is_ret | input | 1 | Pre-decode mark: the fetched instruction is a return |
| pred_hit | output | 1 | A stored or stacked target was found |
| pred_target | output | 32 | Predicted next fetch address |
| rslv_valid | input | 1 | A resolved control transfer is reported |
| rslv_pc | input | 32 | PC of the resolved instruction |
| rslv_target | input | 32 | Actual target |
| rslv_pred_target | input | 32 | Target that was predicted for it |

## Verification
The checker assumes that pre-decode never marks one fetch as both a call and a return, and it checks this as an input rule. The directed sequences always raise at most one of the two flags. The write-then-hit property assumes that the fetch PC in the cycle after a mismatching resolve is not a marked return, since a return would take the stack path. The sequences keep resolves and fetches in separate cycles, so the resolve fields carry no meaning on fetch cycles. They also reach the stack-empty cases only through matched call and return counts, with no stack repair.

// File: rtl/npp_pkg.sv
package npp_pkg;
  localparam int unsigned NPP_ADDR_W    = 32;
  localparam int unsigned NPP_IDX_LO    = 2;
  localparam int unsigned NPP_IDX_W     = 8;
  localparam int unsigned NPP_RAS_DEPTH = 8;

  typedef enum logic [1:0] {
    SRC_SEQ = 2'd0,
    SRC_TBL = 2'd1,
    SRC_STK = 2'd2
  } pred_src_e;
endpackage

// File: rtl/tgt_table.sv
module tgt_table #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_LO = 2,
  parameter int unsigned IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_hit,
  output logic [ADDR_W-1:0] rd_tgt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_pc,
  input  logic [ADDR_W-1:0] wr_tgt
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned TAG_LO  = IDX_LO + IDX_W;
  localparam int unsigned TAG_W   = ADDR_W - TAG_LO;

  function automatic logic [IDX_W-1:0] idx_of(input logic [ADDR_W-1:0] pc);
    return pc[TAG_LO-1:IDX_LO];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] pc);
    return pc[ADDR_W-1:TAG_LO];
  endfunction

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_mem [ENTRIES];
  logic [ADDR_W-1:0]  tgt_mem [ENTRIES];
  logic [IDX_W-1:0]   rd_idx;
  logic [IDX_W-1:0]   wr_idx;
  logic               unused_lo;

  assign rd_idx    = idx_of(rd_pc);
  assign wr_idx    = idx_of(wr_pc);
  assign unused_lo = ^{rd_pc[IDX_LO-1:0], wr_pc[IDX_LO-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx] <= tag_of(wr_pc);
      tgt_mem[wr_idx] <= wr_tgt;
    end
  end

  assign rd_hit = vld_q[rd_idx] && (tag_mem[rd_idx] == tag_of(rd_pc));
  assign rd_tgt = tgt_mem[rd_idx];
endmodule

// File: rtl/ret_stack.sv
module ret_stack #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] push_val,
  output logic [ADDR_W-1:0] top_val,
  output logic              empty
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + PTR_W'(1);
  endfunction

  function automatic logic [PTR_W-1:0] ptr_dec(input logic [PTR_W-1:0] p);
    return (p == '0) ? PTR_MAX : p - PTR_W'(1);
  endfunction

  logic [ADDR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_pop;

  assign empty   = (cnt_q == '0);
  assign do_pop  = pop && !empty;
  assign top_val = mem[ptr_dec(ptr_q)];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else if (push && !do_pop) begin
      ptr_q <= ptr_inc(ptr_q);
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
    end else if (do_pop && !push) begin
      ptr_q <= ptr_dec(ptr_q);
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push && do_pop)  mem[ptr_dec(ptr_q)] <= push_val;
    else if (push)       mem[ptr_q]          <= push_val;
  end
endmodule

// File: rtl/nextpc_predictor.sv
module nextpc_predictor
  import npp_pkg::*;
#(
  parameter int unsigned ADDR_W    = NPP_ADDR_W,
  parameter int unsigned IDX_LO    = NPP_IDX_LO,
  parameter int unsigned IDX_W     = NPP_IDX_W,
  parameter int unsigned RAS_DEPTH = NPP_RAS_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_pc,
  input  logic              fetch_is_call,
  input  logic              fetch_is_ret,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              rslv_valid,
  input  logic [ADDR_W-1:0] rslv_pc,
  input  logic [ADDR_W-1:0] rslv_target,
  input  logic [ADDR_W-1:0] rslv_pred_target
);
  localparam logic [ADDR_W-1:0] INSN_BYTES = ADDR_W'(1) << IDX_LO;

  function automatic logic [ADDR_W-1:0] seq_pc(input logic [ADDR_W-1:0] pc);
    return pc + INSN_BYTES;
  endfunction

  logic              tbl_hit;
  logic [ADDR_W-1:0] tbl_tgt;
  logic              tbl_wr;
  logic              stk_push;
  logic              stk_pop;
  logic              stk_empty;
  logic [ADDR_W-1:0] stk_top;
  logic [ADDR_W-1:0] fall_thru;
  pred_src_e         src;

  assign fall_thru = seq_pc(fetch_pc);
  assign tbl_wr    = rslv_valid && (rslv_target != rslv_pred_target);
  assign stk_push  = fetch_valid && fetch_is_call;
  assign stk_pop   = fetch_valid && fetch_is_ret;

  tgt_table #(.ADDR_W(ADDR_W), .IDX_LO(IDX_LO), .IDX_W(IDX_W)) u_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_pc  (fetch_pc),
    .rd_hit (tbl_hit),
    .rd_tgt (tbl_tgt),
    .wr_en  (tbl_wr),
    .wr_pc  (rslv_pc),
    .wr_tgt (rslv_target)
  );

  ret_stack #(.ADDR_W(ADDR_W), .DEPTH(RAS_DEPTH)) u_stk (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (stk_push),
    .pop      (stk_pop),
    .push_val (fall_thru),
    .top_val  (stk_top),
    .empty    (stk_empty)
  );

  always_comb begin
    if (fetch_is_ret && !stk_empty) src = SRC_STK;
    else if (tbl_hit)               src = SRC_TBL;
    else                            src = SRC_SEQ;
  end

  always_comb begin
    unique case (src)
      SRC_STK: begin pred_hit = 1'b1; pred_target = stk_top;   end
      SRC_TBL: begin pred_hit = 1'b1; pred_target = tbl_tgt;   end
      default: begin pred_hit = 1'b0; pred_target = fall_thru; end
    endcase
  end
endmodule

// File: rtl/nextpc_predictor_chk.sv
module nextpc_predictor_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic              fetch_is_call,
  input logic              fetch_is_ret,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_target,
  input logic              rslv_valid,
  input logic [ADDR_W-1:0] rslv_pc,
  input logic [ADDR_W-1:0] rslv_target,
  input logic [ADDR_W-1:0] rslv_pred_target,
  input logic              tbl_hit,
  input logic              stk_empty
);
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> !(fetch_is_call && fetch_is_ret));

  p_reset_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!tbl_hit && stk_empty));

  p_miss_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (pred_target == fetch_pc + ADDR_W'(4)));

  p_write_then_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rslv_valid && (rslv_target != rslv_pred_target)) ##1
    ((fetch_pc == $past(rslv_pc)) && !fetch_is_ret)
    |-> (pred_hit && (pred_target == $past(rslv_target))));

  p_push_fills_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_is_call) |=> !stk_empty);

  p_empty_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_empty && fetch_valid && fetch_is_ret) |=> stk_empty);

  p_stack_override_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_is_ret && !stk_empty) |-> pred_hit);

  p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && stk_empty) |=> stk_empty);
endmodule

bind nextpc_predictor nextpc_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .fetch_valid      (fetch_valid),
  .fetch_pc         (fetch_pc),
  .fetch_is_call    (fetch_is_call),
  .fetch_is_ret     (fetch_is_ret),
  .pred_hit         (pred_hit),
  .pred_target      (pred_target),
  .rslv_valid       (rslv_valid),
  .rslv_pc          (rslv_pc),
  .rslv_target      (rslv_target),
  .rslv_pred_target (rslv_pred_target),
  .tbl_hit          (tbl_hit),
  .stk_empty        (stk_empty)
);

// File: tb/sim_nextpc_predictor.sv
`timescale 1ns/1ps
module sim_nextpc_predictor;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        fetch_is_call = 1'b0;
  logic        fetch_is_ret = 1'b0;
  logic        pred_hit;
  logic [31:0] pred_target;
  logic        rslv_valid = 1'b0;
  logic [31:0] rslv_pc = '0;
  logic [31:0] rslv_target = '0;
  logic [31:0] rslv_pred_target = '0;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  nextpc_predictor u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .fetch_is_call(fetch_is_call), .fetch_is_ret(fetch_is_ret),
    .pred_hit(pred_hit), .pred_target(pred_target), .rslv_valid(rslv_valid),
    .rslv_pc(rslv_pc), .rslv_target(rslv_target), .rslv_pred_target(rslv_pred_target)
  );

  task automatic cyc(input logic fv, input logic [31:0] pc, input logic c, input logic r,
                     input logic rv, input logic [31:0] rpc, input logic [31:0] rt,
                     input logic [31:0] rp);
    @(negedge clk);
    fetch_valid = fv; fetch_pc = pc; fetch_is_call = c; fetch_is_ret = r;
    rslv_valid = rv; rslv_pc = rpc; rslv_target = rt; rslv_pred_target = rp;
    #1;
  endtask

  task automatic fetch(input logic [31:0] pc, input logic c, input logic r);
    cyc(1'b1, pc, c, r, 1'b0, '0, '0, '0);
  endtask

  task automatic resolve(input logic [31:0] pc, input logic [31:0] t, input logic [31:0] p);
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b1, pc, t, p);
  endtask

  task automatic expect_pred(input string req, input logic eh, input logic [31:0] et);
    checks++;
    if (pred_hit !== eh || pred_target !== et) begin
      fails++;
      $display("FAIL %s: hit=%0b target=%h expected hit=%0b target=%h",
               req, pred_hit, pred_target, eh, et);
    end
  endtask

  task automatic t_reset;
    fetch(32'h0000_1234, 0, 0); expect_pred("R3 R7 after reset", 0, 32'h0000_1238);
    fetch(32'hFFFF_FFFC, 0, 0); expect_pred("R4 miss wraps", 0, 32'h0000_0000);
    fetch(32'h0000_0600, 0, 1); expect_pred("R3 R11 empty stack", 0, 32'h0000_0604);
  endtask

  task automatic t_write;
    resolve(32'h0000_1234, 32'h8000_0040, 32'h0000_1238);
    fetch(32'h0000_1234, 0, 0); expect_pred("R5 write then hit", 1, 32'h8000_0040);
    fetch(32'h0000_1236, 0, 0); expect_pred("R1 low bits ignored", 1, 32'h8000_0040);
    fetch(32'h0000_1634, 0, 0); expect_pred("R2 tag mismatch", 0, 32'h0000_1638);
    fetch(32'h0000_1238, 0, 0); expect_pred("R1 other index", 0, 32'h0000_123C);
  endtask

  task automatic t_nowrite;
    resolve(32'h0000_2000, 32'h0000_3000, 32'h0000_3000);
    fetch(32'h0000_2000, 0, 0); expect_pred("R6 equal leaves miss", 0, 32'h0000_2004);
    resolve(32'h0000_1234, 32'h5555_0000, 32'h5555_0000);
    fetch(32'h0000_1234, 0, 0); expect_pred("R6 equal keeps old", 1, 32'h8000_0040);
    resolve(32'h0000_1234, 32'h9000_0000, 32'h8000_0040);
    fetch(32'h0000_1234, 0, 0); expect_pred("R5 overwrite", 1, 32'h9000_0000);
  endtask

  task automatic t_call_ret;
    fetch(32'h0000_0100, 1, 0); expect_pred("R8 call own lookup", 0, 32'h0000_0104);
    fetch(32'h0000_0500, 0, 1); expect_pred("R8 return pops", 1, 32'h0000_0104);
    fetch(32'h0000_0500, 0, 1); expect_pred("R11 then empty", 0, 32'h0000_0504);
  endtask

  task automatic t_lifo;
    fetch(32'h0000_0100, 1, 0);
    fetch(32'h0000_0200, 1, 0);
    fetch(32'h0000_0300, 1, 0);
    fetch(32'h0000_0A00, 0, 1); expect_pred("R9 lifo 1", 1, 32'h0000_0304);
    fetch(32'h0000_0A00, 0, 1); expect_pred("R9 lifo 2", 1, 32'h0000_0204);
    fetch(32'h0000_0A00, 0, 1); expect_pred("R9 lifo 3", 1, 32'h0000_0104);
    fetch(32'h0000_0A00, 0, 1); expect_pred("R9 drained", 0, 32'h0000_0A04);
  endtask

  task automatic t_overflow;
    for (int i = 0; i < 9; i++) fetch(32'h0000_1000 + 32'(i) * 32'h10, 1, 0);
    for (int k = 0; k < 8; k++) begin
      fetch(32'h0000_0B00, 0, 1);
      expect_pred("R10 wrap order", 1, 32'h0000_1000 + 32'(8 - k) * 32'h10 + 32'h4);
    end
    fetch(32'h0000_0B00, 0, 1); expect_pred("R10 oldest lost", 0, 32'h0000_0B04);
  endtask

  task automatic t_override;
    resolve(32'h0000_0600, 32'h0000_7000, 32'h0000_0604);
    fetch(32'h0000_0040, 1, 0);
    fetch(32'h0000_0600, 0, 1); expect_pred("R12 stack beats table", 1, 32'h0000_0044);
    fetch(32'h0000_0600, 0, 1); expect_pred("R11 empty uses table", 1, 32'h0000_7000);
  endtask

  task automatic t_gating;
    cyc(1'b0, 32'h0000_0080, 1'b1, 1'b0, 1'b0, '0, '0, '0);
    fetch(32'h0000_0900, 0, 1); expect_pred("R13 invalid call no push", 0, 32'h0000_0904);
    fetch(32'h0000_0040, 1, 0);
    cyc(1'b0, 32'h0000_0900, 1'b0, 1'b1, 1'b0, '0, '0, '0);
    fetch(32'h0000_0900, 0, 1); expect_pred("R13 invalid ret no pop", 1, 32'h0000_0044);
    fetch(32'h0000_0900, 0, 1); expect_pred("R13 now empty", 0, 32'h0000_0904);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #400000;
    checks++; fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_write();
    t_nowrite();
    t_call_ret();
    t_lifo();
    t_overflow();
    t_override();
    t_gating();
    cyc(1'b0, '0, 1'b0, 1'b0, 1'b0, '0, '0, '0);
    summary();
  end
endmodule